// File: doc/BRIEF.md
# Circular Event Queue Writer

This block appends one 32-bit entry to a circular event queue kept in memory. A queue descriptor gives its base address, its size as a log-size code, the slot where the next entry goes, and a generation bit. The caller raises `start` for one cycle with the event payload and the four descriptor words. The block stores what it needs from them, computes the address of the slot, builds the entry, and issues a single memory write. When that write completes, it returns descriptor word 1 with a new index and generation bit, so the caller can write the word back.

The generation bit is stored in bit 31 of every entry and flips each time the index wraps to zero. A consumer can therefore tell fresh entries from stale ones without a shared read pointer. If the memory write fails, the descriptor word comes back unchanged and an error flag is raised.

Top module: `evq_post_writer`

## Requirements
- R1: `start` is accepted only while the block is idle. In the cycle after acceptance `mem_req` goes high. `mem_req`, `mem_addr` and `mem_wdata` then hold steady until a cycle in which `mem_ack` or `mem_err` is high. The descriptor inputs may change after acceptance without any effect.
- R2: `mem_addr` equals the 60-bit queue base plus four times the slot index. The base is formed with `desc_w2[27:0]` as its upper 28 bits and `desc_w3` as its lower 32 bits. Bits 31:28 of `desc_w2` play no part.
- R3: `mem_wdata` has the current generation bit (`desc_w1[22]`) in bit 31 and `evt_data[30:0]` in bits 30:0. `evt_data[31]` is ignored.
- R4: The size code is `desc_w0[19:16]` and gives 2^(code+10) entries. Codes above 12 behave as 12. The slot index is `desc_w1[21:0]` with every bit at or above the log of the entry count taken as zero.
- R5: After a write that succeeds, the index advances by one modulo the entry count. When it wraps to zero the generation bit inverts; otherwise the generation bit is kept.
- R6: `done` is high for exactly one cycle: the cycle after the one in which `mem_ack` or `mem_err` was seen. During that cycle `mem_req` is low. `upd_w1` holds the descriptor word 1 that was accepted, with bits 22:0 replaced by the new generation bit and index; bits 31:23 are unchanged.
- R7: If `mem_err` is high in the response cycle, even together with `mem_ack`, `err` is high with `done`. In that case `upd_w1` equals the accepted descriptor word 1 unchanged.
- R8: A `start` raised while a write is pending, or in the `done` cycle, is ignored: no new write is issued after `done`.
- R9: While reset is held, `mem_req`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to post an entry |
| evt_data | input | 32 | Event payload; bits 30:0 are stored |
| desc_w0 | input | 32 | Descriptor word 0; size code in bits 19:16 |
| desc_w1 | input | 32 | Descriptor word 1; generation bit 22, index 21:0 |
| desc_w2 | input | 32 | Descriptor word 2; base upper bits in 27:0 |
| desc_w3 | input | 32 | Descriptor word 3; base lower 32 bits |
| mem_req | output | 1 | Memory write request, held until a response |
| mem_addr | output | 60 | Byte address of the slot being written |
| mem_wdata | output | 32 | Entry being written |
| mem_ack | input | 1 | Write completed |
| mem_err | input | 1 | Write failed |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with `done` |
| upd_w1 | output | 32 | Updated descriptor word 1, valid with `done` |

## Verification
The memory request is due one cycle after the edge that accepts `start`. It must stay unchanged on every following cycle until the bench answers, and the bench scrambles the descriptor inputs during that wait. The completion pulse, the error flag and the updated word are due exactly one cycle after the edge that samples the response. The pulse must be gone one cycle later. The bench drives inputs and samples outputs on the falling edge. It steps its model alongside the design through each of these cycles and compares every output in the cycle it is due: request, address and data on each waiting cycle, and completion at its fixed offset. Late `start` pulses placed in the waiting and completion cycles are checked by confirming that no request follows.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [1:0] {
    EVQ_IDLE,
    EVQ_BUSY,
    EVQ_DONE
  } evq_state_e;

  localparam int EVQ_WORD_W   = 32;
  localparam int EVQ_CODE_LSB = 16;
endpackage

// File: rtl/evq_slot_calc.sv
// Slot arithmetic: index mask from the size code, slot address, entry word.
module evq_slot_calc #(
  parameter int IDX_W   = 22,
  parameter int ADDR_W  = 60,
  parameter int LOG_MIN = 10,
  parameter int CODE_W  = 4
) (
  input  logic [CODE_W-1:0] size_code,
  input  logic [IDX_W:0]    w1_low,
  input  logic [ADDR_W-33:0] base_hi,
  input  logic [31:0]       base_lo,
  input  logic [30:0]       evt,
  output logic [IDX_W-1:0]  idx_mask,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              cur_gen,
  output logic [ADDR_W-1:0] slot_addr,
  output logic [31:0]       slot_word
);
  localparam int HI_W = ADDR_W - 32;

  function automatic logic [7:0] eff_log(input logic [CODE_W-1:0] c);
    logic [7:0] s;
    s = 8'(c) + 8'(LOG_MIN);
    if (s > 8'(IDX_W)) s = 8'(IDX_W);
    return s;
  endfunction

  function automatic logic [ADDR_W-1:0] slot_of(input logic [ADDR_W-1:0] b,
                                                input logic [IDX_W-1:0] i);
    return b + (ADDR_W'(i) << 2);
  endfunction

  function automatic logic [31:0] entry_of(input logic g, input logic [30:0] d);
    return {g, d};
  endfunction

  logic [7:0]        log_len;
  logic [ADDR_W-1:0] base;

  assign log_len = eff_log(size_code);

  for (genvar i = 0; i < IDX_W; i++) begin : g_mask
    assign idx_mask[i] = (8'(i) < log_len);
  end

  assign base      = {base_hi[HI_W-1:0], base_lo};
  assign cur_idx   = w1_low[IDX_W-1:0] & idx_mask;
  assign cur_gen   = w1_low[IDX_W];
  assign slot_addr = slot_of(base, cur_idx);
  assign slot_word = entry_of(cur_gen, evt);
endmodule

// File: rtl/evq_ptr_step.sv
// Next index and generation after one successful post.
module evq_ptr_step #(
  parameter int IDX_W = 22
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             cur_gen,
  input  logic [IDX_W-1:0] idx_mask,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             nxt_gen,
  output logic             wrapped
);
  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i,
                                                input logic [IDX_W-1:0] m);
    return (i + IDX_W'(1)) & m;
  endfunction

  assign nxt_idx = step_idx(cur_idx, idx_mask);
  assign wrapped = (nxt_idx == '0);
  assign nxt_gen = wrapped ? ~cur_gen : cur_gen;
endmodule

// File: rtl/evq_post_writer.sv
module evq_post_writer #(
  parameter int IDX_W   = 22,
  parameter int ADDR_W  = 60,
  parameter int LOG_MIN = 10,
  parameter int CODE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       evt_data,
  input  logic [31:0]       desc_w0,
  input  logic [31:0]       desc_w1,
  input  logic [31:0]       desc_w2,
  input  logic [31:0]       desc_w3,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              done,
  output logic              err,
  output logic [31:0]       upd_w1
);
  import evq_pkg::*;

  localparam int HI_W     = ADDR_W - 32;
  localparam int CODE_LSB = EVQ_CODE_LSB;

  evq_state_e        state;
  logic [CODE_W-1:0] lat_code;
  logic [31:0]       lat_w1;
  logic [HI_W-1:0]   lat_base_hi;
  logic [31:0]       lat_base_lo;
  logic [30:0]       lat_evt;

  // named events for the checker
  logic accept_evt, resp_ok, resp_fail;

  logic [IDX_W-1:0] idx_mask, cur_idx, nxt_idx;
  logic             cur_gen, nxt_gen, wrapped;

  logic unused_fields;
  assign unused_fields = ^{desc_w0[31:CODE_LSB+CODE_W], desc_w0[CODE_LSB-1:0],
                           desc_w2[31:HI_W], evt_data[31]};

  assign accept_evt = (state == EVQ_IDLE) && start;
  assign resp_fail  = (state == EVQ_BUSY) && mem_err;
  assign resp_ok    = (state == EVQ_BUSY) && mem_ack && !mem_err;
  assign mem_req    = (state == EVQ_BUSY);

  evq_slot_calc #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LOG_MIN(LOG_MIN), .CODE_W(CODE_W)
  ) u_slot (
    .size_code (lat_code),
    .w1_low    (lat_w1[IDX_W:0]),
    .base_hi   (lat_base_hi),
    .base_lo   (lat_base_lo),
    .evt       (lat_evt),
    .idx_mask  (idx_mask),
    .cur_idx   (cur_idx),
    .cur_gen   (cur_gen),
    .slot_addr (mem_addr),
    .slot_word (mem_wdata)
  );

  evq_ptr_step #(.IDX_W(IDX_W)) u_step (
    .cur_idx  (cur_idx),
    .cur_gen  (cur_gen),
    .idx_mask (idx_mask),
    .nxt_idx  (nxt_idx),
    .nxt_gen  (nxt_gen),
    .wrapped  (wrapped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= EVQ_IDLE;
      done        <= 1'b0;
      err         <= 1'b0;
      upd_w1      <= '0;
      lat_code    <= '0;
      lat_w1      <= '0;
      lat_base_hi <= '0;
      lat_base_lo <= '0;
      lat_evt     <= '0;
    end else begin
      case (state)
        EVQ_IDLE: begin
          if (accept_evt) begin
            lat_code    <= desc_w0[CODE_LSB +: CODE_W];
            lat_w1      <= desc_w1;
            lat_base_hi <= desc_w2[HI_W-1:0];
            lat_base_lo <= desc_w3;
            lat_evt     <= evt_data[30:0];
            state       <= EVQ_BUSY;
          end
        end
        EVQ_BUSY: begin
          if (resp_fail) begin
            upd_w1 <= lat_w1;
            err    <= 1'b1;
            done   <= 1'b1;
            state  <= EVQ_DONE;
          end else if (resp_ok) begin
            upd_w1 <= {lat_w1[31:IDX_W+1], nxt_gen, nxt_idx};
            err    <= 1'b0;
            done   <= 1'b1;
            state  <= EVQ_DONE;
          end
        end
        EVQ_DONE: begin
          done  <= 1'b0;
          err   <= 1'b0;
          state <= EVQ_IDLE;
        end
        default: state <= EVQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evq_post_chk.sv
module evq_post_chk #(
  parameter int IDX_W  = 22,
  parameter int ADDR_W = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic              mem_err,
  input logic              done,
  input logic              err,
  input logic [31:0]       upd_w1,
  input logic              accept_evt,
  input logic              resp_ok,
  input logic              resp_fail,
  input logic [IDX_W-1:0]  hold_idx,
  input logic [IDX_W-1:0]  hold_raw_idx,
  input logic              hold_gen
);
  a_r1_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> mem_req);

  a_r1_req_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  a_r3_gen_in_entry: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_wdata[31] == hold_gen));

  a_r5_wrap_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && upd_w1[IDX_W-1:0] == '0) |-> (upd_w1[IDX_W] != hold_gen));

  a_r5_step_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && upd_w1[IDX_W-1:0] != '0) |->
      (upd_w1[IDX_W] == hold_gen && upd_w1[IDX_W-1:0] == IDX_W'(hold_idx + 1'b1)));

  a_r6_done_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_ok || resp_fail) |=> (done && !mem_req));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_fail_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (upd_w1[IDX_W-1:0] == hold_raw_idx && upd_w1[IDX_W] == hold_gen));

  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_req);
endmodule

bind evq_post_writer evq_post_chk #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req      (mem_req),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_ack      (mem_ack),
  .mem_err      (mem_err),
  .done         (done),
  .err          (err),
  .upd_w1       (upd_w1),
  .accept_evt   (accept_evt),
  .resp_ok      (resp_ok),
  .resp_fail    (resp_fail),
  .hold_idx     (cur_idx),
  .hold_raw_idx (lat_w1[IDX_W-1:0]),
  .hold_gen     (cur_gen)
);

// File: tb/sim_evq_post_writer.sv
module sim_evq_post_writer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, mem_ack, mem_err;
  logic [31:0] evt_data, desc_w0, desc_w1, desc_w2, desc_w3;
  logic        mem_req, done, err;
  logic [59:0] mem_addr;
  logic [31:0] mem_wdata, upd_w1;

  int vectors = 0;
  int miscompares = 0;

  evq_post_writer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .evt_data(evt_data),
    .desc_w0(desc_w0), .desc_w1(desc_w1), .desc_w2(desc_w2), .desc_w3(desc_w3),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err),
    .done(done), .err(err), .upd_w1(upd_w1)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_w1(input logic [8:0] top, input logic g, input int idx);
    return {top, g, 22'(idx)};
  endfunction

  // behavioural model plus cycle stepping of one post
  task automatic post(input logic [31:0] w0, w1, w2, w3, data,
                      input int lat, input bit fail, input bit ack_too,
                      input bit poke, output logic [31:0] nw1);
    int          code;
    longint      ents;
    longint      idx, nidx;
    logic        gen, ngen;
    logic [59:0] exp_addr;
    logic [31:0] exp_word;
    code = int'(w0[19:16]);
    if (code > 12) code = 12;
    ents = longint'(1) << (code + 10);
    idx  = longint'(w1[21:0]) % ents;
    gen  = w1[22];
    exp_addr = {w2[27:0], w3} + 60'(idx * 4);
    exp_word = {gen, data[30:0]};
    nidx = (idx + 1) % ents;
    ngen = (nidx == 0) ? !gen : gen;
    nw1  = fail ? w1 : {w1[31:23], ngen, 22'(nidx)};

    @(negedge clk);
    desc_w0 = w0; desc_w1 = w1; desc_w2 = w2; desc_w3 = w3; evt_data = data;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    desc_w0 = ~w0; desc_w1 = ~w1; desc_w2 = ~w2; desc_w3 = ~w3; evt_data = ~data;
    for (int k = 0; k <= lat; k++) begin
      start = (poke && k == 0 && lat > 0);   // R8: start while busy
      chk("R1 mem_req while pending", 64'(mem_req), 64'd1);
      chk("R2 mem_addr", 64'(mem_addr), 64'(exp_addr));
      chk("R3 mem_wdata", 64'(mem_wdata), 64'(exp_word));
      chk("R6 done low while pending", 64'(done), 64'd0);
      if (k == lat) begin
        mem_err = fail;
        mem_ack = !fail || ack_too;
      end
      @(negedge clk);
      mem_ack = 1'b0; mem_err = 1'b0; start = 1'b0;
    end
    chk("R6 done pulse", 64'(done), 64'd1);
    chk("R6 mem_req low with done", 64'(mem_req), 64'd0);
    chk(fail ? "R7 err flag" : "R5 err clear", 64'(err), 64'(fail));
    chk(fail ? "R7 upd_w1 unchanged" : "R5 upd_w1", 64'(upd_w1), 64'(nw1));
    start = poke;                             // R8: start in done cycle
    @(negedge clk);
    start = 1'b0;
    chk("R6 done single cycle", 64'(done), 64'd0);
    chk("R8 no request after done", 64'(mem_req), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; start = 1'b0; mem_ack = 1'b0; mem_err = 1'b0;
    evt_data = '0; desc_w0 = '0; desc_w1 = '0; desc_w2 = '0; desc_w3 = '0;
    repeat (3) @(negedge clk);
    chk("R9 mem_req in reset", 64'(mem_req), 64'd0);
    chk("R9 done in reset", 64'(done), 64'd0);
    chk("R9 err in reset", 64'(err), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", 64'(mem_req), 64'd0);

    // R2 R3 plain post, code 0
    post(32'h0000_0000, mk_w1(9'h000, 1'b0, 5), 32'h0000_0012, 32'h3400_0000,
         32'h1234_5678, 0, 0, 0, 0, r);
    // R3 payload bit 31 ignored
    post(32'h0000_0000, mk_w1(9'h1A5, 1'b1, 77), 32'h0000_0000, 32'h0001_0000,
         32'hFFFF_FFFF, 2, 0, 0, 0, r);
    // R5 wrap 0 -> 1 and 1 -> 0
    post(32'h0000_0000, mk_w1(9'h000, 1'b0, 1023), 32'h0, 32'h8000, 32'h0000_0001, 1, 0, 0, 0, r);
    post(32'h0000_0000, mk_w1(9'h0F0, 1'b1, 1023), 32'h0, 32'h8000, 32'h0000_0002, 0, 0, 0, 0, r);
    // R4 code 4, 16K entries, wrap
    post(32'h0004_0000, mk_w1(9'h155, 1'b0, 16383), 32'h5, 32'h0, 32'h4000_0001, 1, 0, 0, 0, r);
    // R4 code 4 without wrap at 1024
    post(32'h0004_0000, mk_w1(9'h000, 1'b0, 1023), 32'h5, 32'h0, 32'h4000_0001, 0, 0, 0, 0, r);
    // R4 code above 12 clamps to 12
    post(32'h000F_0000, mk_w1(9'h0AA, 1'b0, 22'h3FFFFF), 32'h1, 32'h0, 32'h7, 0, 0, 0, 0, r);
    post(32'h000C_0000, mk_w1(9'h000, 1'b1, 22'h3FFFFE), 32'h1, 32'h0, 32'h8, 0, 0, 0, 0, r);
    // R4 index bits above queue size taken as zero
    post(32'hFFF0_FFFF, mk_w1(9'h000, 1'b0, 32'h1500), 32'h0, 32'h0, 32'h9, 0, 0, 0, 0, r);
    // R2 base carry into upper part, w2 top bits ignored
    post(32'h0000_0000, mk_w1(9'h000, 1'b0, 1), 32'hF000_0001, 32'hFFFF_FFFC, 32'hA, 0, 0, 0, 0, r);
    // R7 failure, then failure with simultaneous ack
    post(32'h0000_0000, mk_w1(9'h1FF, 1'b1, 1023), 32'h0, 32'h100, 32'hB, 3, 1, 0, 0, r);
    post(32'h0000_0000, mk_w1(9'h001, 1'b0, 9), 32'h0, 32'h100, 32'hC, 1, 1, 1, 0, r);
    // R8 start pokes while busy and in done cycle
    post(32'h0000_0000, mk_w1(9'h000, 1'b0, 40), 32'h2, 32'h0, 32'hD, 2, 0, 0, 1, r);
    post(32'h0000_0000, mk_w1(9'h000, 1'b0, 41), 32'h2, 32'h0, 32'hE, 0, 0, 0, 1, r);
    // R5 chained posts through a wrap, feeding back the returned word
    r = mk_w1(9'h033, 1'b0, 1021);
    for (int n = 0; n < 5; n++) begin
      logic [31:0] w;
      w = r;
      post(32'h0000_0000, w, 32'h0, 32'h2000_0000, 32'(n + 100), n % 3, 0, 0, 0, r);
    end
    chk("R5 chain end word", 64'(r), 64'(mk_w1(9'h033, 1'b1, 2)));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule